// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block performs one shift or rotate per accepted operation on a 32-bit operand. It covers zero-filling shifts in both directions, a sign-preserving right shift, an arithmetic left shift that also reports signed overflow, plain rotates in both directions, and rotates in both directions that pass through the carry flag. For the carry rotates, the carry flag acts as one extra bit of a 33-bit ring. The amount comes from a 5-bit count. Every operation defines its carry-out. A count of zero passes both the operand and the incoming carry through untouched.

An execution stage presents the operand, count, operation code and current carry flag together with a valid strobe. One clock later the block returns the result with the updated carry, negative, zero and overflow flags, and raises an output valid for that cycle. While no operation is presented, the registered outputs keep their last values.

Top module: `shift_rot_unit`

## Requirements
- R1: While reset is held, and after it is released until the first operation, out_valid, result, carry_out, negative, zero and overflow are all 0.
- R2: Operation code 0 (shift left, zero fill) moves the operand left by the count and fills the low positions with zeros. carry_out takes the last bit moved out, which is operand bit 32-count.
- R3: Operation code 1 (shift right, zero fill) moves the operand right by the count and fills the high positions with zeros. carry_out takes operand bit count-1.
- R4: Operation code 2 (arithmetic right) moves the operand right by the count and copies bit 31 into every vacated high position. carry_out takes operand bit count-1.
- R5: Operation code 3 (arithmetic left) gives the same result and carry as code 0. It sets overflow when any bit shifted out differs from bit 31 of the result. Every other code leaves overflow at 0.
- R6: Operation codes 4 (rotate left) and 5 (rotate right) move the bits that leave one end into the other end. carry_out receives the last bit that wrapped.
- R7: Operation codes 6 (rotate left through carry) and 7 (rotate right through carry) rotate the 33-bit ring formed by carry_in and the operand. The bit that leaves the word goes into carry_out, and the old carry re-enters at the opposite end. The rotation amount is the count modulo 33.
- R8: A count of 0 returns the operand unchanged, returns carry_in as carry_out and clears overflow, for every operation code.
- R9: negative equals result bit 31. zero is 1 exactly when all 32 result bits are 0.
- R10: Outputs update one clock after a cycle with in_valid high, and out_valid is high for exactly that following cycle. Cycles with in_valid low leave result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| operand | input | 32 | Value to shift or rotate |
| count | input | 5 | Shift or rotate amount, 0 to 31 |
| op | input | 3 | Operation code (see R2 to R7) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | Updated carry flag |
| negative | output | 1 | Result bit 31 |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of the arithmetic left shift |

## Verification
The carry update and the zero flag can be set by the same operation. This happens when the last 1 leaves the word. For example, a zero-fill right shift of 1 by one position gives a zero result together with a set carry, and a left rotate through carry can park the only set bit in the carry. Overflow and carry can likewise rise together on an arithmetic left shift that pushes out a 1 past a changed sign. These cases are driven as directed items, next to a long pseudo-random stream. The scoreboard compares carry, zero, negative and overflow as one expected item, so a design that lets one of them mask the other is caught in that cycle.

// File: rtl/shr_pkg.sv
package shr_pkg;
    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_SAL  = 3'd3,
        OP_ROTL = 3'd4,
        OP_ROTR = 3'd5,
        OP_RCL  = 3'd6,
        OP_RCR  = 3'd7
    } shr_op_e;
endpackage

// File: rtl/shr_core.sv
module shr_core
    import shr_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [CW-1:0]    n,
    input  shr_op_e          op,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf
);
    localparam int RW = WIDTH + 1;

    logic [2*WIDTH-1:0]        ext_l;
    logic [2*WIDTH-1:0]        ext_r;
    logic signed [2*WIDTH-1:0] ext_a;
    logic [2*WIDTH-1:0]        dbl_l;
    logic [2*WIDTH-1:0]        dbl_r;
    logic [RW-1:0]             ring;
    logic [2*RW-1:0]           rdbl_l;
    logic [2*RW-1:0]           rdbl_r;
    logic [CW:0]               eff;
    logic                      sal_v;

    // Counts never reach RW, so count modulo RW equals the count.
    assign eff  = {1'b0, n} % (CW+1)'(RW);
    assign ring = {cin, a};

    always_comb begin
        ext_l  = {{WIDTH{1'b0}}, a} << n;
        ext_r  = {a, {WIDTH{1'b0}}} >> n;
        ext_a  = $signed({a, {WIDTH{1'b0}}}) >>> n;
        dbl_l  = {a, a} << n;
        dbl_r  = {a, a} >> n;
        rdbl_l = {ring, ring} << eff;
        rdbl_r = {ring, ring} >> eff;
    end

    // Overflow of left arithmetic shift: top n+1 bits must all agree.
    always_comb begin
        sal_v = 1'b0;
        for (int i = 1; i < WIDTH; i++) begin
            if (i <= int'(n) && a[WIDTH-1-i] != a[WIDTH-1]) sal_v = 1'b1;
        end
    end

    always_comb begin
        res  = a;
        cout = cin;
        ovf  = 1'b0;
        if (n != '0) begin
            unique case (op)
                OP_SHL, OP_SAL: begin
                    res  = ext_l[WIDTH-1:0];
                    cout = ext_l[WIDTH];
                    ovf  = (op == OP_SAL) && sal_v;
                end
                OP_SHR: begin
                    res  = ext_r[2*WIDTH-1:WIDTH];
                    cout = ext_r[WIDTH-1];
                end
                OP_SAR: begin
                    res  = ext_a[2*WIDTH-1:WIDTH];
                    cout = ext_a[WIDTH-1];
                end
                OP_ROTL: begin
                    res  = dbl_l[2*WIDTH-1:WIDTH];
                    cout = dbl_l[WIDTH];
                end
                OP_ROTR: begin
                    res  = dbl_r[WIDTH-1:0];
                    cout = dbl_r[WIDTH-1];
                end
                OP_RCL: begin
                    res  = rdbl_l[2*RW-2:RW];
                    cout = rdbl_l[2*RW-1];
                end
                OP_RCR: begin
                    res  = rdbl_r[WIDTH-1:0];
                    cout = rdbl_r[WIDTH];
                end
                default: begin
                    res  = a;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    output logic             neg,
    output logic             zero
);
    assign neg  = res[WIDTH-1];
    assign zero = ~|res;
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import shr_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CW    = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] operand,
    input  logic [CW-1:0]    count,
    input  logic [2:0]       op,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             negative,
    output logic             zero,
    output logic             overflow
);
    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] res;
        logic             c;
        logic             n;
        logic             z;
        logic             v;
    } shr_state_t;

    shr_state_t st_d, st_q;
    logic [WIDTH-1:0] core_res;
    logic             core_c, core_v, core_n, core_z;

    shr_core #(.WIDTH(WIDTH), .CW(CW)) u_core (
        .a    (operand),
        .n    (count),
        .op   (shr_op_e'(op)),
        .cin  (carry_in),
        .res  (core_res),
        .cout (core_c),
        .ovf  (core_v)
    );

    shr_flags #(.WIDTH(WIDTH)) u_flags (
        .res  (core_res),
        .neg  (core_n),
        .zero (core_z)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = core_res;
            st_d.c   = core_c;
            st_d.n   = core_n;
            st_d.z   = core_z;
            st_d.v   = core_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign carry_out = st_q.c;
    assign negative  = st_q.n;
    assign zero      = st_q.z;
    assign overflow  = st_q.v;

    // R8
    cnt0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && count == '0) |=> (result == $past(operand) &&
                                       carry_out == $past(carry_in) && !overflow));
    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zero == (result == '0)));
    // R9
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (negative == result[WIDTH-1]));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 3'(OP_SAL)) |=> !overflow);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out)));
    // R2
    shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'(OP_SHL)) |=>
            ((result & ~({WIDTH{1'b1}} << $past(count))) == '0));
    // R4
    sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'(OP_SAR)) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));
endmodule

// File: tb/sim_shift_rot_unit.sv
module sim_shift_rot_unit;
    typedef struct packed {
        logic [31:0] res;
        logic        c;
        logic        n;
        logic        z;
        logic        v;
        logic [2:0]  op;
        logic [4:0]  cnt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  count = '0;
    logic [2:0]  op = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, carry_out, negative, zero, overflow;
    logic [31:0] result;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    shift_rot_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .count(count), .op(op), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .carry_out(carry_out), .negative(negative),
        .zero(zero), .overflow(overflow)
    );

    function automatic string req_of(input logic [2:0] o, input logic [4:0] k);
        if (k == 0) return "R8";
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Step-by-step reference, one position per iteration.
    function automatic exp_t model(input logic [31:0] a, input logic [4:0] k,
                                   input logic [2:0] o, input logic ci);
        exp_t e;
        logic [31:0] r = a;
        logic c = ci;
        logic t;
        bit out1 = 0, out0 = 0;
        for (int i = 0; i < int'(k); i++) begin
            case (o)
                3'd0, 3'd3: begin c = r[31]; if (c) out1 = 1; else out0 = 1; r = r << 1; end
                3'd1: begin c = r[0]; r = r >> 1; end
                3'd2: begin c = r[0]; r = {r[31], r[31:1]}; end
                3'd4: begin c = r[31]; r = {r[30:0], r[31]}; end
                3'd5: begin c = r[0]; r = {r[0], r[31:1]}; end
                3'd6: begin t = r[31]; r = {r[30:0], c}; c = t; end
                default: begin t = r[0]; r = {c, r[31:1]}; c = t; end
            endcase
        end
        e.res = r; e.c = c; e.n = r[31]; e.z = (r == 0);
        e.v = (o == 3'd3 && k != 0) ? (r[31] ? out0 : out1) : 1'b0;
        e.op = o; e.cnt = k;
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [4:0] k,
                         input logic [2:0] o, input logic ci);
        @(negedge clk);
        operand = a; count = k; op = o; carry_in = ci; in_valid = 1'b1;
        sb_q.push_back(model(a, k, o, ci));
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand = 32'hDEAD_BEEF ^ i; count = 5'd7; op = 3'd6; carry_in = 1'b1;
        end
    endtask

    // Monitor: pops one expected item per valid output.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
            end else begin
                e = sb_q.pop_front();
                last_exp = e;
                if ({result, carry_out, negative, zero, overflow} !== {e.res, e.c, e.n, e.z, e.v}) begin
                    n_fail++;
                    $display("FAIL %s/R9 op=%0d cnt=%0d: actual res=%h c=%b n=%b z=%b v=%b expected res=%h c=%b n=%b z=%b v=%b",
                             req_of(e.op, e.cnt), e.op, e.cnt, result, carry_out, negative, zero,
                             overflow, e.res, e.c, e.n, e.z, e.v);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({out_valid, result, carry_out, negative, zero, overflow} !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: actual %h expected 0",
                     {out_valid, result, carry_out, negative, zero, overflow});
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if ({out_valid, result} !== '0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual %h expected 0", {out_valid, result});
        end

        // R2 / R3 / R4 directed
        drive(32'h8000_0001, 5'd1, 3'd0, 1'b0);
        drive(32'h4000_0000, 5'd2, 3'd0, 1'b0);
        drive(32'hFFFF_FFFF, 5'd31, 3'd0, 1'b0);
        drive(32'h0000_0001, 5'd1, 3'd1, 1'b0);   // zero result with carry set
        drive(32'h8000_0000, 5'd31, 3'd1, 1'b0);
        drive(32'h8000_0010, 5'd4, 3'd2, 1'b0);
        drive(32'h7FFF_FFFF, 5'd31, 3'd2, 1'b1);
        // R5 arithmetic left: overflow and not
        drive(32'h4000_0000, 5'd1, 3'd3, 1'b0);
        drive(32'hE000_0000, 5'd2, 3'd3, 1'b0);
        drive(32'hC000_0000, 5'd2, 3'd3, 1'b0);
        drive(32'h0000_0001, 5'd31, 3'd3, 1'b0);
        // R6 rotates
        drive(32'h8000_0003, 5'd2, 3'd4, 1'b0);
        drive(32'h0000_0001, 5'd1, 3'd5, 1'b0);
        drive(32'h1234_5678, 5'd31, 3'd5, 1'b1);
        // R7 rotate through carry, ring of 33 bits
        drive(32'h8000_0000, 5'd1, 3'd6, 1'b0);   // only 1 parks in carry: zero result
        drive(32'h0000_0000, 5'd31, 3'd6, 1'b1);
        drive(32'h0000_0001, 5'd1, 3'd7, 1'b1);
        drive(32'hA5A5_0F0F, 5'd31, 3'd7, 1'b0);
        // R8 zero count, every code
        for (int o = 0; o < 8; o++) drive(32'h9ABC_DEF0, 5'd0, 3'(o), o[0]);
        idle(1);

        // R10: idle cycles keep outputs
        idle(4);
        n_checks++;
        if (out_valid !== 1'b0 || result !== last_exp.res || carry_out !== last_exp.c) begin
            n_fail++;
            $display("FAIL R10 hold: actual v=%b res=%h c=%b expected v=0 res=%h c=%b",
                     out_valid, result, carry_out, last_exp.res, last_exp.c);
        end

        // Pseudo-random stream, with gaps
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr ^ (i * 32'h9E37_79B9), lfsr[4:0], lfsr[10:8], lfsr[13]);
            if (lfsr[17:16] == 2'b00) idle(1);
        end
        idle(3);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 pending items: actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule